// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Front End

This block is the bus-facing controller of a 4K x 8 nonvolatile memory model. It watches the two-wire bus through SCL and SDA inputs, which are already synchronised to the system clock, and finds START and STOP conditions. It then takes in a device-select byte and compares it with three strap pins. For a write it collects a 12-bit byte address and hands each following data byte to a write cache as a single-cycle strobe. For a read it fetches bytes from a synchronous RAM and shifts them onto the bus. SDA is driven only as an open-drain pull-down enable.

The system clock must run much faster than SCL. Every change of the SDA enable is held back by a programmable number of system cycles after SCL falls. This stops the block's own SDA transitions from looking like bus conditions. While the memory reports an internal program cycle, the block acknowledges nothing.

Top module: `twi_eeprom_slave`

## Requirements
- R1: A falling SDA while SCL is high (START) sends the block back to device-select reception from any state, even in the middle of a byte, and a byte received right after it is handled as a fresh device-select byte.
- R2: A rising SDA while SCL is high (STOP) returns the block to idle. Until the next START, bytes clocked on the bus get no acknowledge and cause no write.
- R3: The device-select byte is received MSB first. Bits 7..4 must be 1010 and bits 3..1 must equal `dev_sel_i[2:0]`, or the block gives no acknowledge and ignores the bus until the next START. Bit 0 set to 1 means read and 0 means write.
- R4: After each byte that addresses it, the block sets `sda_oe_o` so that SDA is low throughout the high phase of the ninth clock.
- R5: If `prog_busy_i` is high when a byte completes, that byte is not acknowledged and not written, and the rest of the transfer is dropped until the next START.
- R6: After a write select byte, the next two bytes set the byte address, high byte first. Bits 3..0 of the first byte become address bits 11..8 and its bits 7..4 are ignored.
- R7: Each further byte of a write produces exactly one `wr_en_o` pulse of one cycle, carrying the current address and the byte, and the address then increases by one.
- R8: A read select byte starts transmission, MSB first, of the byte stored at the current address. A write select byte with two address bytes, then a repeated START and a read select byte, therefore reads from the new address.
- R9: In a read, each master acknowledge moves to the next address. The address wraps from 0xFFF to 0x000.
- R10: A master non-acknowledge after a read byte ends the read. SDA stays released until the next START.
- R11: `sda_oe_o` never changes while SCL is high. Each change comes at least HOLD_CYC cycles after the SCL falling edge that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Synchronised bus clock |
| sda_i | input | 1 | Synchronised bus data (wired line) |
| dev_sel_i | input | 3 | Strap value for device-select bits 3..1 |
| prog_busy_i | input | 1 | Internal program cycle in progress |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| wr_en_o | output | 1 | One-cycle write strobe to the cache |
| wr_addr_o | output | 12 | Byte address of the write |
| wr_data_o | output | 8 | Byte to write |
| rd_addr_o | output | 12 | Read address for the synchronous RAM |
| rd_data_i | input | 8 | RAM read data, one cycle after the address |

## Verification
The checker tests on every cycle that the SDA enable stays still while SCL is high and in the cycle after SCL falls. It also tests that write strobes last one cycle and never follow a cycle with a program cycle in progress. Device-select decoding, address assembly, wrap-around, the mid-byte START and the effect of non-acknowledge depend on whole byte sequences. Only the bench's scenarios can show these. The bench sweeps all eight strap values against all eight select codes and compares read data with a memory pattern it computes itself.

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave #(
  parameter int AW       = 12,
  parameter int HOLD_CYC = 60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [2:0]    dev_sel_i,
  input  logic          prog_busy_i,
  output logic          sda_oe_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [7:0]    rd_data_i
);
  localparam int HW = $clog2(HOLD_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_CTRL, S_AHI, S_ALO, S_WR, S_RD} st_t;

  st_t           st;
  logic          scl_q, sda_q;
  logic [3:0]    cnt;
  logic          ackph, ack_q, mnack;
  logic [7:0]    sr, tx;
  logic [AW-1:0] addr;
  logic [HW-1:0] hold;

  wire scl_rise = scl_i & ~scl_q;
  wire scl_fall = ~scl_i & scl_q;
  wire start_c  = scl_i & scl_q & sda_q & ~sda_i;
  wire stop_c   = scl_i & scl_q & ~sda_q & sda_i;
  wire match    = (sr[7:4] == 4'b1010) && (sr[3:1] == dev_sel_i);
  wire take     = !prog_busy_i && (st != S_CTRL || match);
  wire want     = ackph ? ack_q : (st == S_RD && !tx[7]);

  assign rd_addr_o = addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;  scl_q <= 1'b1;  sda_q <= 1'b1;
      cnt <= '0;  ackph <= 1'b0;  ack_q <= 1'b0;  mnack <= 1'b1;
      sr <= '0;  tx <= '1;  addr <= '0;  hold <= '0;
      sda_oe_o <= 1'b0;  wr_en_o <= 1'b0;  wr_addr_o <= '0;  wr_data_o <= '0;
    end else begin
      scl_q   <= scl_i;
      sda_q   <= sda_i;
      wr_en_o <= 1'b0;
      if (scl_fall) hold <= HOLD_CYC[HW-1:0];
      else if (hold != '0) hold <= hold - 1'b1;
      if (hold == '0) sda_oe_o <= want;

      if (start_c) begin
        st <= S_CTRL;  cnt <= '0;  ackph <= 1'b0;  ack_q <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE;  cnt <= '0;  ackph <= 1'b0;  ack_q <= 1'b0;
      end else if (st != S_IDLE) begin
        if (scl_rise) begin
          if (ackph) mnack <= sda_i;
          else if (cnt < 4'd8) begin
            cnt <= cnt + 1'b1;
            if (st != S_RD) sr <= {sr[6:0], sda_i};
          end
        end else if (scl_fall) begin
          if (ackph) begin
            ackph <= 1'b0;  ack_q <= 1'b0;  cnt <= '0;
            if (st == S_RD) begin
              if (mnack) st <= S_IDLE;
              else begin tx <= rd_data_i; addr <= addr + 1'b1; end
            end else if (!ack_q) st <= S_IDLE;
            else begin
              case (st)
                S_CTRL: if (sr[0]) begin
                          st <= S_RD;  tx <= rd_data_i;  addr <= addr + 1'b1;
                        end else st <= S_AHI;
                S_AHI:  st <= S_ALO;
                S_ALO:  st <= S_WR;
                default: ;
              endcase
            end
          end else if (cnt == 4'd8) begin
            ackph <= 1'b1;
            if (st != S_RD) ack_q <= take;
            if (take) begin
              case (st)
                S_AHI: addr[AW-1:8] <= sr[AW-9:0];
                S_ALO: addr[7:0]    <= sr;
                S_WR: begin
                  wr_en_o <= 1'b1;  wr_addr_o <= addr;  wr_data_o <= sr;
                  addr <= addr + 1'b1;
                end
                default: ;
              endcase
            end
          end else if (st == S_RD && cnt != 4'd0) tx <= {tx[6:0], 1'b1};
        end
      end
    end
  end
endmodule

module twi_eeprom_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe_o,
  input logic wr_en_o,
  input logic prog_busy_i
);
  AST_OE_STILL_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i)) |-> $stable(sda_oe_o)); // R11
  AST_OE_HOLD_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_i) |=> $stable(sda_oe_o)); // R11
  AST_WR_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> !$past(prog_busy_i)); // R5
  AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> !wr_en_o); // R7
endmodule

bind twi_eeprom_slave twi_eeprom_slave_chk u_chk (.*);

// File: tb/twi_eeprom_slave_tb.sv
module twi_eeprom_slave_tb;
  localparam int HOLD = 8;
  localparam int Q    = 20;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        scl_i = 1'b1, sda_m = 1'b1;
  logic [2:0]  dev_sel = 3'd0;
  logic        busy = 1'b0;
  logic        sda_oe, wr_en;
  logic [11:0] wr_addr, rd_addr;
  logic [7:0]  wr_data, rd_data;
  wire         sda_i = sda_m & ~sda_oe;

  logic [7:0]  mem [0:4095];
  int          checks = 0, fails = 0, wr_cnt = 0;
  logic [11:0] last_a;
  logic [7:0]  last_d;
  int          since = 0, early = 0, hi_chg = 0;
  logic        pscl = 1'b1, poe = 1'b0;

  always #2.5 clk = ~clk;

  twi_eeprom_slave #(.AW(12), .HOLD_CYC(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .dev_sel_i(dev_sel),
    .prog_busy_i(busy), .sda_oe_o(sda_oe), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .rd_addr_o(rd_addr), .rd_data_i(rd_data));

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  always @(posedge clk) rd_data <= mem[rd_addr];

  always @(negedge clk) begin
    if (wr_en) begin
      mem[wr_addr] = wr_data;  wr_cnt++;  last_a = wr_addr;  last_d = wr_data;
    end
    if (!scl_i && pscl) since = 0; else since++;
    if (rst_n && sda_oe !== poe) begin
      if (scl_i && pscl) hi_chg++;
      if (since < HOLD) early++;
    end
    pscl = scl_i;  poe = sda_oe;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_i = 1'b1; wq(); sda_m = 1'b0; wq(); scl_i = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_i = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic clk_bit(input logic b, output logic seen);
    sda_m = b; wq(); scl_i = 1'b1; wq(); seen = sda_i; wq(); scl_i = 1'b0; wq();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); d[i] = s; end
    clk_bit(~mack, s);
    sda_m = 1'b1;
  endtask

  task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo);
    logic a;
    bus_start();
    wbyte(8'hAA, a); chk(a, "R3 select ack", a, 1);
    wbyte(hi, a);    chk(a, "R4 addr-high ack", a, 1);
    wbyte(lo, a);    chk(a, "R4 addr-low ack", a, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d;
    int n;
    for (int i = 0; i < 4096; i++) mem[i] = pat(i);
    repeat (5) @(posedge clk);
    #1;
    chk(sda_oe == 1'b0 && wr_en == 1'b0, "reset outputs idle", {sda_oe, wr_en}, 0);
    rst_n = 1'b1;
    wq();

    // R3 sweep: every strap value against every select code
    for (int p = 0; p < 8; p++) begin
      dev_sel = 3'(p);
      for (int c = 0; c < 8; c++) begin
        bus_start();
        wbyte({4'b1010, 3'(c), 1'b0}, a);
        chk(a == (c == p), "R3 select decode", a, int'(c == p));
        bus_stop();
      end
    end
    dev_sel = 3'd5;
    bus_start(); wbyte(8'hBA, a); chk(!a, "R3 wrong family code", a, 0); bus_stop();

    // R6 R7 write with ignored upper address nibble
    n = wr_cnt;
    set_addr(8'hF3, 8'h4E);
    wbyte(8'h5A, a); chk(a, "R4 data ack", a, 1);
    chk(wr_cnt == n + 1 && last_a == 12'h34E, "R6 write address", last_a, 12'h34E);
    chk(last_d == 8'h5A, "R7 write data", last_d, 8'h5A);
    wbyte(8'hC3, a);
    chk(wr_cnt == n + 2 && last_a == 12'h34F && last_d == 8'hC3, "R7 address increment", last_a, 12'h34F);
    wbyte(8'h01, a);
    chk(wr_cnt == n + 3 && last_a == 12'h350, "R7 third byte", last_a, 12'h350);
    bus_stop();

    // R8 random read via repeated START, R10 release
    set_addr(8'h03, 8'h4F);
    bus_start(); wbyte(8'hAB, a); chk(a, "R8 read select ack", a, 1);
    rbyte(1'b0, d); chk(d == 8'hC3, "R8 random read data", d, 8'hC3);
    wq(); chk(sda_oe == 1'b0, "R10 SDA released after nack", sda_oe, 0);
    bus_stop();

    // R9 sequential read across wrap
    set_addr(8'h0F, 8'hFE);
    bus_start(); wbyte(8'hAB, a);
    rbyte(1'b1, d); chk(d == pat(12'hFFE), "R9 seq byte 0", d, pat(12'hFFE));
    rbyte(1'b1, d); chk(d == pat(12'hFFF), "R9 seq byte 1", d, pat(12'hFFF));
    rbyte(1'b1, d); chk(d == pat(0), "R9 wrap to zero", d, pat(0));
    rbyte(1'b0, d); chk(d == pat(1), "R9 seq after wrap", d, pat(1));
    bus_stop();
    bus_start(); wbyte(8'hAB, a);
    rbyte(1'b0, d); chk(d == pat(2), "R8 current address read", d, pat(2));
    bus_stop();

    // R5 busy at select and at a data byte
    n = wr_cnt;
    busy = 1'b1;
    bus_start(); wbyte(8'hAA, a); chk(!a, "R5 select while busy", a, 0);
    wbyte(8'h00, a); wbyte(8'h10, a); wbyte(8'h77, a);
    chk(!a && wr_cnt == n, "R5 dropped transfer", wr_cnt - n, 0);
    bus_stop();
    busy = 1'b0;
    set_addr(8'h01, 8'h00);
    busy = 1'b1; wbyte(8'h99, a); busy = 1'b0;
    chk(!a && wr_cnt == n, "R5 data byte while busy", a, 0);
    wbyte(8'h88, a);
    chk(!a && wr_cnt == n, "R5 rest dropped", a, 0);
    bus_stop();

    // R2 bytes after STOP are ignored
    bus_start(); wbyte(8'hAA, a); bus_stop();
    wbyte(8'hAA, a); chk(!a, "R2 no ack after stop", a, 0);
    wbyte(8'h12, a); chk(!a && wr_cnt == n, "R2 no write after stop", wr_cnt - n, 0);
    bus_stop();

    // R1 START in the middle of a byte
    bus_start();
    clk_bit(1'b1, a); clk_bit(1'b0, a); clk_bit(1'b1, a); clk_bit(1'b0, a);
    bus_start(); wbyte(8'hAB, a); chk(a, "R1 restart mid-byte", a, 1);
    rbyte(1'b0, d); chk(d == pat(12'h100), "R1 read after restart", d, pat(12'h100));
    bus_stop();

    // R11 timing of every SDA enable change
    chk(hi_chg == 0, "R11 no change while SCL high", hi_chg, 0);
    chk(early == 0, "R11 hold after SCL fall", early, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule